// File: doc/BRIEF.md
# RAM ECC Error Bank

This block keeps a small table of RAM addresses where the ECC checker found a fault, and it keeps those addresses out of use. The checker sends one report per detected error: a strobe, the faulty address and a flag that says whether the error could be corrected. Each new address takes the lowest free slot. From then on a combinational lookup marks that address as blocked for the allocation logic. Two output pins pulse to announce correctable and uncorrectable errors.

Software reads each slot through a select index. After it has analysed a location, it writes back a verdict. A soft verdict frees the slot and unblocks the address. A hard verdict retires the address for good. The slot count is a parameter: 3, 2 or 1 slots, depending on which RAM the bank guards. If a report arrives when every slot is taken, the report is dropped and a sticky overflow flag is raised.

Top module: `ecc_err_bank`

## Requirements
- R1: A report (`rpt_valid`=1) whose address matches no valid slot, arriving while a slot is free, is stored in the lowest-numbered free slot at the next clock edge. The slot becomes valid, holds the address and has its hard bit at 0.
- R2: `qry_blocked` is 1 in the same cycle exactly when `qry_addr` equals the address of some valid slot.
- R3: A report whose address equals the address of a valid slot stores nothing new.
- R4: A report with a new address while all slots are valid is dropped and sets `ovf_flag` at the next edge. `ovf_flag` stays set until a cycle with `sw_ovf_clr`=1 and no overflow event clears it. If both happen in the same cycle, the set wins.
- R5: A classify write (`sw_cls_we`=1, `sw_cls_hard`=0) to a valid slot that is not hard clears that slot at the next edge, which unblocks its address.
- R6: A classify write with `sw_cls_hard`=1 to a valid slot sets its hard bit. Once a slot is hard, later classify writes to it have no effect and the slot stays valid.
- R7: `irq_corr` pulses for one cycle, one cycle after a correctable report (`rpt_uncorr`=0), but only if `cfg_notify` is not 2'b00. With 2'b00 the report is still logged, and no pulse occurs.
- R8: `irq_uncorr` pulses for one cycle, one cycle after any report with `rpt_uncorr`=1, whatever `cfg_notify` holds.
- R9: A classify write to an invalid slot, or with `sw_sel` >= ENTRIES, changes nothing. Reads with `sw_sel` >= ENTRIES return zeros.
- R10: While `rst` is high at a clock edge, every slot, the overflow flag and both pulse outputs are cleared.
- R11: `sw_rd_valid`, `sw_rd_hard` and `sw_rd_addr` show, in the same cycle, the state of the slot chosen by `sw_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Error report strobe |
| rpt_addr | input | AW | Faulty RAM address |
| rpt_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| cfg_notify | input | 2 | Correctable notification enable; 2'b00 silences |
| qry_addr | input | AW | Address asked about by allocation logic |
| qry_blocked | output | 1 | Query address is held by a valid slot |
| sw_sel | input | IW | Slot index for software read and classify |
| sw_rd_valid | output | 1 | Selected slot valid |
| sw_rd_hard | output | 1 | Selected slot classified hard |
| sw_rd_addr | output | AW | Selected slot address |
| sw_cls_we | input | 1 | Classify write strobe |
| sw_cls_hard | input | 1 | Verdict: 1 = hard, 0 = soft |
| sw_ovf_clr | input | 1 | Clear overflow flag |
| ovf_flag | output | 1 | Sticky overflow |
| irq_corr | output | 1 | Correctable error pulse |
| irq_uncorr | output | 1 | Uncorrectable error pulse |

## Verification
The assertions assume that every input is a known value outside reset. They also assume that a report carries one address for one cycle. Under those assumptions, a slot is only taken from the free set, and slot occupancy can grow by at most one per cycle.

The stimulus draws addresses from a pool of a few values, so duplicates and overflow happen often. It also sends classify writes to every index, including the unused one. All inputs change only on the falling edge.

// File: rtl/ecc_err_bank_pkg.sv
package ecc_err_bank_pkg;
  typedef enum logic {VERDICT_SOFT = 1'b0, VERDICT_HARD = 1'b1} verdict_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/err_slot.sv
module err_slot #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_addr,
  input  logic          cls_we,
  input  logic          cls_hard,
  input  logic [AW-1:0] qry_addr,
  input  logic [AW-1:0] rpt_addr,
  output logic          valid,
  output logic          hard,
  output logic [AW-1:0] addr,
  output logic          q_hit,
  output logic          r_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      hard  <= 1'b0;
      addr  <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      hard  <= 1'b0;
      addr  <= alloc_addr;
    end else if (cls_we && valid && !hard) begin
      if (cls_hard == ecc_err_bank_pkg::VERDICT_HARD) hard <= 1'b1;
      else valid <= 1'b0;
    end
  end

  assign q_hit = valid && (addr == qry_addr);
  assign r_hit = valid && (addr == rpt_addr);
endmodule

// File: rtl/err_pick.sv
module err_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--)
      if (free_vec[i]) grant = N'(1) << i;
  end
endmodule

// File: rtl/err_notify.sv
module err_notify (
  input  logic       clk,
  input  logic       rst,
  input  logic       rpt_valid,
  input  logic       rpt_uncorr,
  input  logic [1:0] cfg_notify,
  output logic       irq_corr,
  output logic       irq_uncorr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_corr   <= 1'b0;
      irq_uncorr <= 1'b0;
    end else begin
      irq_corr   <= rpt_valid && !rpt_uncorr && (cfg_notify != 2'b00);
      irq_uncorr <= rpt_valid && rpt_uncorr;
    end
  end
endmodule

// File: rtl/ecc_err_bank.sv
module ecc_err_bank #(
  parameter int ENTRIES = 3,
  parameter int AW      = 10,
  localparam int IW     = ecc_err_bank_pkg::idx_width(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rpt_valid,
  input  logic [AW-1:0] rpt_addr,
  input  logic          rpt_uncorr,
  input  logic [1:0]    cfg_notify,
  input  logic [AW-1:0] qry_addr,
  output logic          qry_blocked,
  input  logic [IW-1:0] sw_sel,
  output logic          sw_rd_valid,
  output logic          sw_rd_hard,
  output logic [AW-1:0] sw_rd_addr,
  input  logic          sw_cls_we,
  input  logic          sw_cls_hard,
  input  logic          sw_ovf_clr,
  output logic          ovf_flag,
  output logic          irq_corr,
  output logic          irq_uncorr
);
  logic [ENTRIES-1:0] ent_valid, ent_hard, q_hits, r_hits, grant, alloc_vec, cls_vec;
  logic [AW-1:0]      ent_addr [ENTRIES];
  logic               dup, full, take, spill;

  assign dup   = |r_hits;
  assign full  = &ent_valid;
  assign take  = rpt_valid && !dup && !full;
  assign spill = rpt_valid && !dup && full;

  err_pick #(.N(ENTRIES)) u_pick (.free_vec(~ent_valid), .grant(grant));

  assign alloc_vec = take ? grant : '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign cls_vec[g] = sw_cls_we && (32'(sw_sel) == g);
    err_slot #(.AW(AW)) u_slot (
      .clk(clk), .rst(rst),
      .alloc(alloc_vec[g]), .alloc_addr(rpt_addr),
      .cls_we(cls_vec[g]), .cls_hard(sw_cls_hard),
      .qry_addr(qry_addr), .rpt_addr(rpt_addr),
      .valid(ent_valid[g]), .hard(ent_hard[g]), .addr(ent_addr[g]),
      .q_hit(q_hits[g]), .r_hit(r_hits[g])
    );
  end

  assign qry_blocked = |q_hits;

  always_comb begin
    sw_rd_valid = 1'b0;
    sw_rd_hard  = 1'b0;
    sw_rd_addr  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (32'(sw_sel) == i) begin
        sw_rd_valid = ent_valid[i];
        sw_rd_hard  = ent_hard[i];
        sw_rd_addr  = ent_addr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             ovf_flag <= 1'b0;
    else if (spill)      ovf_flag <= 1'b1;
    else if (sw_ovf_clr) ovf_flag <= 1'b0;
  end

  err_notify u_notify (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_uncorr(rpt_uncorr),
    .cfg_notify(cfg_notify), .irq_corr(irq_corr), .irq_uncorr(irq_uncorr)
  );
endmodule

// File: rtl/ecc_err_bank_chk.sv
module ecc_err_bank_chk #(
  parameter int ENTRIES = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               rpt_valid,
  input logic               rpt_uncorr,
  input logic [1:0]         cfg_notify,
  input logic               sw_ovf_clr,
  input logic               ovf_flag,
  input logic               irq_corr,
  input logic               irq_uncorr,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ent_hard
);
  a_r8_uncorr_pulse: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && rpt_uncorr |=> irq_uncorr);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(rpt_valid && rpt_uncorr) |=> !irq_uncorr);
  a_r7_corr_pulse: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && !rpt_uncorr && cfg_notify != 2'b00 |=> irq_corr);
  a_r7_silenced: assert property (@(posedge clk) disable iff (rst)
    !(rpt_valid && !rpt_uncorr && cfg_notify != 2'b00) |=> !irq_corr);
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !sw_ovf_clr |=> ovf_flag);
  a_r4_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    sw_ovf_clr && !rpt_valid |=> !ovf_flag);
  a_r1_one_alloc: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(ent_valid) <= $countones($past(ent_valid)) + 1);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    a_r6_hard_kept: assert property (@(posedge clk) disable iff (rst)
      ent_hard[g] |=> ent_hard[g] && ent_valid[g]);
    a_r6_hard_valid: assert property (@(posedge clk) disable iff (rst)
      ent_hard[g] |-> ent_valid[g]);
  end
endmodule

bind ecc_err_bank ecc_err_bank_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_uncorr(rpt_uncorr),
  .cfg_notify(cfg_notify), .sw_ovf_clr(sw_ovf_clr), .ovf_flag(ovf_flag),
  .irq_corr(irq_corr), .irq_uncorr(irq_uncorr),
  .ent_valid(ent_valid), .ent_hard(ent_hard)
);

// File: tb/tb_ecc_err_bank.sv
module tb_ecc_err_bank;
  localparam int E  = 3;
  localparam int AW = 10;
  localparam int IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic rpt_valid = 0, rpt_uncorr = 0, sw_cls_we = 0, sw_cls_hard = 0, sw_ovf_clr = 0;
  logic [AW-1:0] rpt_addr = '0, qry_addr = '0;
  logic [1:0] cfg_notify = '0;
  logic [IW-1:0] sw_sel = '0;
  logic qry_blocked, sw_rd_valid, sw_rd_hard, ovf_flag, irq_corr, irq_uncorr;
  logic [AW-1:0] sw_rd_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mv[E], mh[E];
  logic [AW-1:0] ma[E];
  bit movf, exp_c, exp_u;

  always #10 clk = ~clk;

  ecc_err_bank #(.ENTRIES(E), .AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_blocked(input logic [AW-1:0] a);
    for (int i = 0; i < E; i++) if (mv[i] && ma[i] == a) return 1;
    return 0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < E; i++) begin mv[i] = 0; mh[i] = 0; ma[i] = '0; end
    movf = 0; exp_c = 0; exp_u = 0;
  endtask

  task automatic step(input bit rv, input int ra, input bit ru, input int cfg,
                      input int qa, input int sel, input bit we, input bit hd,
                      input bit clr, input string tag);
    int slot;
    bit dup, full;
    @(negedge clk);
    rpt_valid = rv; rpt_addr = AW'(ra); rpt_uncorr = ru; cfg_notify = 2'(cfg);
    qry_addr = AW'(qa); sw_sel = IW'(sel); sw_cls_we = we; sw_cls_hard = hd; sw_ovf_clr = clr;
    #2;
    chk(qry_blocked == m_blocked(AW'(qa)), {tag, " R2 qry_blocked"}, qry_blocked, m_blocked(AW'(qa)));
    if (sel < E) begin
      chk(sw_rd_valid == mv[sel], {tag, " R11 rd_valid"}, sw_rd_valid, mv[sel]);
      chk(sw_rd_hard == mh[sel], {tag, " R6 rd_hard"}, sw_rd_hard, mh[sel]);
      chk(sw_rd_addr == ma[sel], {tag, " R1 rd_addr"}, sw_rd_addr, ma[sel]);
    end else begin
      chk({sw_rd_valid, sw_rd_hard, sw_rd_addr} == '0, {tag, " R9 rd out of range"}, sw_rd_addr, 0);
    end
    chk(ovf_flag == movf, {tag, " R4 ovf_flag"}, ovf_flag, movf);
    chk(irq_corr == exp_c, {tag, " R7 irq_corr"}, irq_corr, exp_c);
    chk(irq_uncorr == exp_u, {tag, " R8 irq_uncorr"}, irq_uncorr, exp_u);
    // next-state model from pre-edge state
    dup = rv && m_blocked(AW'(ra));
    full = 1; slot = -1;
    for (int i = E - 1; i >= 0; i--) if (!mv[i]) begin full = 0; slot = i; end
    if (we && sel < E && mv[sel] && !mh[sel]) begin
      if (hd) mh[sel] = 1; else mv[sel] = 0;
    end
    if (rv && !dup && !full) begin mv[slot] = 1; mh[slot] = 0; ma[slot] = AW'(ra); end
    if (rv && !dup && full) movf = 1; else if (clr) movf = 0;
    exp_c = rv && !ru && cfg != 0;
    exp_u = rv && ru;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rpt_valid = 0; sw_cls_we = 0; sw_ovf_clr = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 0;
    model_clear();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 10, i, 0, 0, 0, "R10 reset state");
    // R1 fill with correctable errors, notifications silenced (R7)
    step(1, 10, 0, 0, 10, 0, 0, 0, 0, "R1 R7 first");
    step(1, 11, 0, 0, 10, 0, 0, 0, 0, "R1 R7 second");
    step(1, 11, 0, 3, 11, 1, 0, 0, 0, "R3 duplicate");
    step(1, 12, 1, 0, 11, 1, 0, 0, 0, "R1 R8 third uncorr");
    step(1, 13, 0, 1, 12, 2, 0, 0, 0, "R4 overflow");
    step(0, 0, 0, 0, 13, 2, 0, 0, 0, "R4 dropped");
    step(0, 0, 0, 0, 11, 1, 1, 0, 0, "R5 soft verdict");
    step(0, 0, 0, 0, 11, 1, 0, 0, 0, "R5 unblocked");
    step(0, 0, 0, 0, 10, 0, 1, 1, 0, "R6 hard verdict");
    step(0, 0, 0, 0, 10, 0, 1, 0, 0, "R6 soft ignored");
    step(0, 0, 0, 0, 10, 0, 0, 0, 0, "R6 still retired");
    step(0, 0, 0, 0, 10, 3, 1, 0, 0, "R9 out of range");
    step(0, 0, 0, 0, 10, 1, 1, 1, 0, "R9 invalid slot");
    step(1, 14, 0, 2, 14, 1, 0, 0, 1, "R1 R4 refill and clear");
    step(1, 15, 0, 2, 15, 1, 0, 0, 1, "R4 set beats clear");
    step(0, 0, 0, 0, 15, 1, 0, 0, 1, "R4 clear");
    step(0, 0, 0, 0, 15, 2, 0, 0, 0, "R4 cleared");
    for (int n = 0; n < 4000; n++) begin
      step($urandom % 5 < 2, 20 + $urandom % 6, $urandom % 4 == 0, $urandom % 4,
           20 + $urandom % 6, $urandom % 4, $urandom % 5 == 0, $urandom % 2,
           $urandom % 20 == 0, "random");
      if (n == 2000) begin
        do_reset();
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 20 + i, i, 0, 0, 0, "R10 mid reset");
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule